// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block picks, every clock cycle, at most one warp from a pool of resident warps and grants it the right to issue its next instruction. Each warp presents a "has an instruction" flag and the kind of that instruction. An arithmetic instruction keeps its warp out of the running for a short fixed number of cycles. A memory load keeps it out until the memory system returns a response tagged with that warp's index. While some warps wait, the scheduler keeps issuing from the others, so long memory latencies are covered by work from other warps.

Among the eligible warps the choice rotates: the search starts just after the warp granted last and wraps around. Grants, the idle flag and a saturating stall counter are all registered. The result of the choice made in one cycle appears on the outputs in the next cycle. A core with several partitions instantiates one scheduler per partition, each over its own warp slice.

Top module: `wsched_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, grant_valid, grant_id, grant_is_load, idle and stall_count are all zero. The first search after reset begins at warp 0.
- R2: A warp is eligible in a decision cycle when its warp_valid bit is high, it has no outstanding load, and it is not inside an arithmetic busy window. grant_valid is high in the cycle after a decision cycle exactly when at least one warp was eligible. At most one warp is granted per cycle, and grant_id is 0 whenever grant_valid is low.
- R3: The granted warp is the first eligible one found by scanning upward from the index after the last granted warp, wrapping from NUM_WARPS-1 to 0.
- R4: A warp granted while its warp_is_load bit is 1 (memory load) is not eligible again until ret_valid is high with ret_tag equal to its index in some cycle r. It is then eligible in decision cycle r+1, and its grant is visible in cycle r+2.
- R5: A warp granted in decision cycle t while its warp_is_load bit is 0 (arithmetic) is next eligible in decision cycle t+ALU_LAT.
- R6: A return whose tag names a warp with no outstanding load has no effect. This includes a return arriving in the same cycle that warp's load is chosen; that load remains outstanding.
- R7: idle is high in the cycle after a decision cycle in which no warp was eligible. It is never high together with grant_valid.
- R8: stall_count rises by one for every decision cycle with no eligible warp, stops at its all-ones value, and otherwise holds.
- R9: grant_is_load equals the warp_is_load bit that the granted warp presented in its decision cycle, and is 0 when there is no grant.
- R10: A warp whose warp_valid bit is low is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_valid | input | NUM_WARPS | Per warp: resident with an instruction ready to issue |
| warp_is_load | input | NUM_WARPS | Per warp: 1 = next instruction is a memory load, 0 = arithmetic |
| ret_valid | input | 1 | A memory return arrives this cycle |
| ret_tag | input | $clog2(NUM_WARPS) | Index of the warp the return belongs to |
| grant_valid | output | 1 | A warp was granted (registered) |
| grant_id | output | $clog2(NUM_WARPS) | Index of the granted warp, 0 when none |
| grant_is_load | output | 1 | The granted instruction is a memory load |
| idle | output | 1 | No warp was eligible in the previous cycle |
| stall_count | output | STALL_W | Saturating count of idle decision cycles |

## Verification
Two events can act on the scheduler's wait state in the same edge: a memory return that wakes one warp, and a load grant that puts a warp to sleep. When both name the same warp, the return is ignored and the load stays outstanding. The bench sweeps every combination of valid and kind patterns on a four-warp configuration while returns arrive every cycle with a rotating tag. A directed case sends a return to a warp in the very cycle its load is chosen. The outputs are compared each cycle against a model derived from the requirements, including the following cycles in which the warp must stay silent.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef enum logic {
    OP_ALU  = 1'b0,
    OP_LOAD = 1'b1
  } op_kind_e;
endpackage

// File: rtl/wsched_warp_slot.sv
// Per-warp hazard state: one outstanding-load flag and an arithmetic busy countdown.
module wsched_warp_slot #(
  parameter int ALU_LAT = 4,
  parameter int CW      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  has_instr,
  input  logic                  issue,
  input  wsched_pkg::op_kind_e  issue_kind,
  input  logic                  ret_hit,
  output logic                  eligible
);
  import wsched_pkg::*;

  localparam logic [CW-1:0] RELOAD = CW'(ALU_LAT - 1);

  logic          waiting;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      // a new load outranks a return arriving at the same edge
      if (issue && issue_kind == OP_LOAD) begin
        waiting <= 1'b1;
      end else if (ret_hit) begin
        waiting <= 1'b0;
      end
      if (issue && issue_kind == OP_ALU) begin
        busy_cnt <= RELOAD;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  assign eligible = has_instr && !waiting && (busy_cnt == '0);
endmodule

// File: rtl/wsched_rr_pick.sv
// Rotating-priority pick: first request above the last winner, wrapping.
module wsched_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/wsched_sat_ctr.sv
// Saturating up-counter.
module wsched_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/wsched_core.sv
module wsched_core #(
  parameter int NUM_WARPS = 8,
  parameter int ALU_LAT   = 4,
  parameter int STALL_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_WARPS-1:0]         warp_valid,
  input  logic [NUM_WARPS-1:0]         warp_is_load,
  input  logic                         ret_valid,
  input  logic [$clog2(NUM_WARPS)-1:0] ret_tag,
  output logic                         grant_valid,
  output logic [$clog2(NUM_WARPS)-1:0] grant_id,
  output logic                         grant_is_load,
  output logic                         idle,
  output logic [STALL_W-1:0]           stall_count
);
  import wsched_pkg::*;

  localparam int ID_W  = $clog2(NUM_WARPS);
  localparam int CNT_W = $clog2(ALU_LAT + 1);

  logic [NUM_WARPS-1:0] eligible;
  logic [NUM_WARPS-1:0] issue;
  logic [NUM_WARPS-1:0] ret_hit;
  logic [ID_W-1:0]      last_q;
  logic [ID_W-1:0]      pick;
  logic                 found;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    assign issue[w]   = found && (pick == ID_W'(w));
    assign ret_hit[w] = ret_valid && (ret_tag == ID_W'(w));

    wsched_warp_slot #(
      .ALU_LAT (ALU_LAT),
      .CW      (CNT_W)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .has_instr  (warp_valid[w]),
      .issue      (issue[w]),
      .issue_kind (op_kind_e'(warp_is_load[w])),
      .ret_hit    (ret_hit[w]),
      .eligible   (eligible[w])
    );
  end

  wsched_rr_pick #(
    .N  (NUM_WARPS),
    .IW (ID_W)
  ) u_pick (
    .req   (eligible),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  wsched_sat_ctr #(
    .W (STALL_W)
  ) u_stall (
    .clk   (clk),
    .rst   (rst),
    .inc   (!found),
    .count (stall_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid   <= 1'b0;
      grant_id      <= '0;
      grant_is_load <= 1'b0;
      idle          <= 1'b0;
      last_q        <= ID_W'(NUM_WARPS - 1);
    end else begin
      grant_valid   <= found;
      grant_id      <= found ? pick : '0;
      grant_is_load <= found && (op_kind_e'(warp_is_load[pick]) == OP_LOAD);
      idle          <= !found;
      if (found) begin
        last_q <= pick;
      end
    end
  end
endmodule

// File: rtl/wsched_core_chk.sv
module wsched_core_chk #(
  parameter int NUM_WARPS = 8,
  parameter int ALU_LAT   = 4,
  parameter int STALL_W   = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_WARPS-1:0]         warp_valid,
  input logic                         ret_valid,
  input logic [$clog2(NUM_WARPS)-1:0] ret_tag,
  input logic                         grant_valid,
  input logic [$clog2(NUM_WARPS)-1:0] grant_id,
  input logic                         grant_is_load,
  input logic                         idle,
  input logic [STALL_W-1:0]           stall_count
);
  localparam int ID_W = $clog2(NUM_WARPS);
  localparam int GW   = $clog2(ALU_LAT + 1);
  localparam logic [STALL_W-1:0] SMAX = {STALL_W{1'b1}};

  logic [NUM_WARPS-1:0] valid_d;
  logic [NUM_WARPS-1:0] pend;
  logic [GW-1:0]        gap [NUM_WARPS];

  always_ff @(posedge clk) begin
    valid_d <= warp_valid;
    if (rst) begin
      pend <= '0;
      for (int w = 0; w < NUM_WARPS; w++) gap[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        if (ret_valid && ret_tag == ID_W'(w)) pend[w] <= 1'b0;
        else if (grant_valid && grant_is_load && grant_id == ID_W'(w)) pend[w] <= 1'b1;
        if (grant_valid && !grant_is_load && grant_id == ID_W'(w)) gap[w] <= GW'(ALU_LAT - 1);
        else if (gap[w] != '0) gap[w] <= gap[w] - 1'b1;
      end
    end
  end

  assert_no_grant_invalid_R10: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> valid_d[grant_id]);
  assert_id_zero_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !grant_valid |-> grant_id == '0);
  assert_idle_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(idle && grant_valid));
  assert_load_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !pend[grant_id]);
  assert_alu_gap_R5: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> gap[grant_id] == '0);
  assert_stall_step_R8: assert property (@(posedge clk) disable iff (rst)
    (idle && $past(stall_count) != SMAX) |-> stall_count == $past(stall_count) + 1'b1);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !idle |-> $stable(stall_count));
endmodule

bind wsched_core wsched_core_chk #(
  .NUM_WARPS (NUM_WARPS),
  .ALU_LAT   (ALU_LAT),
  .STALL_W   (STALL_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .warp_valid    (warp_valid),
  .ret_valid     (ret_valid),
  .ret_tag       (ret_tag),
  .grant_valid   (grant_valid),
  .grant_id      (grant_id),
  .grant_is_load (grant_is_load),
  .idle          (idle),
  .stall_count   (stall_count)
);

// File: tb/tb_wsched_core.sv
module tb_wsched_core;
  localparam int NW  = 4;
  localparam int LAT = 3;
  localparam int SW  = 4;
  localparam int IW  = 2;
  localparam int SMAX = 15;

  logic          clk = 1'b0;
  logic          rst;
  logic [NW-1:0] warp_valid;
  logic [NW-1:0] warp_is_load;
  logic          ret_valid;
  logic [IW-1:0] ret_tag;
  logic          grant_valid;
  logic [IW-1:0] grant_id;
  logic          grant_is_load;
  logic          idle;
  logic [SW-1:0] stall_count;

  always #5 clk = ~clk;

  wsched_core #(.NUM_WARPS(NW), .ALU_LAT(LAT), .STALL_W(SW)) dut (
    .clk(clk), .rst(rst), .warp_valid(warp_valid), .warp_is_load(warp_is_load),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .grant_valid(grant_valid),
    .grant_id(grant_id), .grant_is_load(grant_is_load), .idle(idle),
    .stall_count(stall_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  int mw [NW];
  int ac [NW];
  int last_m, st_m;
  int e_gv, e_gid, e_gl, e_idle, e_st;

  task automatic cmp(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; warp_valid = '0; warp_is_load = '0; ret_valid = 1'b0; ret_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < NW; w++) begin mw[w] = 0; ac[w] = 0; end
    last_m = NW - 1; st_m = 0;
  endtask

  // at a falling edge: drive, predict, advance one cycle, compare
  task automatic step(string ph, logic [NW-1:0] v, logic [NW-1:0] ld, logic rv, int rt);
    int any, pk;
    warp_valid = v; warp_is_load = ld; ret_valid = rv; ret_tag = IW'(rt);
    any = 0; pk = 0;
    for (int k = 1; k <= NW; k++) begin
      int idx;
      idx = (last_m + k) % NW;
      if (any == 0 && v[idx] && mw[idx] == 0 && ac[idx] == 0) begin any = 1; pk = idx; end
    end
    for (int w = 0; w < NW; w++) begin
      if (any == 1 && pk == w && ld[w]) mw[w] = 1;
      else if (rv && rt == w) mw[w] = 0;
      if (any == 1 && pk == w && !ld[w]) ac[w] = LAT - 1;
      else if (ac[w] > 0) ac[w] = ac[w] - 1;
    end
    if (any == 1) last_m = pk;
    else if (st_m < SMAX) st_m = st_m + 1;
    e_gv = any; e_gid = (any == 1) ? pk : 0; e_gl = (any == 1 && ld[pk]) ? 1 : 0;
    e_idle = 1 - any; e_st = st_m;
    @(negedge clk);
    cmp({ph, " R2 grant_valid"}, int'(grant_valid), e_gv);
    cmp({ph, " R3 grant_id"}, int'(grant_id), e_gid);
    cmp({ph, " R9 grant_is_load"}, int'(grant_is_load), e_gl);
    cmp({ph, " R7 idle"}, int'(idle), e_idle);
    cmp({ph, " R8 stall_count"}, int'(stall_count), e_st);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    rst = 1'b1; warp_valid = '0; warp_is_load = '0; ret_valid = 1'b0; ret_tag = '0;

    // R1: reset state
    do_reset();
    cmp("R1 grant_valid", int'(grant_valid), 0);
    cmp("R1 grant_id", int'(grant_id), 0);
    cmp("R1 grant_is_load", int'(grant_is_load), 0);
    cmp("R1 idle", int'(idle), 0);
    cmp("R1 stall_count", int'(stall_count), 0);
    step("R1", 4'b1111, 4'b0000, 1'b0, 0);
    cmp("R1 first pick is warp 0", int'(grant_id), 0);

    // R5: lone arithmetic warp issues every LAT cycles
    do_reset();
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      step("R5", 4'b0001, 4'b0000, 1'b0, 0);
      cnt += int'(grant_valid);
    end
    cmp("R5 arithmetic grants in 12 cycles", cnt, 4);

    // R4: load blocks until its return, then wakes one cycle later
    do_reset();
    step("R4", 4'b0001, 4'b0001, 1'b0, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step("R4", 4'b0001, 4'b0001, 1'b0, 0);
      cnt += int'(grant_valid);
    end
    cmp("R4 grants while load outstanding", cnt, 0);
    step("R4", 4'b0001, 4'b0001, 1'b1, 0);
    cmp("R4 no grant in return cycle", int'(grant_valid), 0);
    step("R4", 4'b0001, 4'b0000, 1'b0, 0);
    cmp("R4 grant after return", int'(grant_valid), 1);

    // R6: return in the same cycle the load is chosen, and a return to another warp
    do_reset();
    step("R6", 4'b0001, 4'b0001, 1'b1, 0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      step("R6", 4'b0001, 4'b0001, 1'b1, 1);
      cnt += int'(grant_valid);
    end
    cmp("R6 stray returns leave load outstanding", cnt, 0);

    // R10 and R8: nothing valid, idle every cycle, counter saturates
    do_reset();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step("R10", 4'b0000, 4'b1111, 1'b0, 0);
      cnt += int'(grant_valid);
    end
    cmp("R10 grants with no valid warp", cnt, 0);
    cmp("R8 stall_count saturated", int'(stall_count), SMAX);

    // R3: rotating order over four loads
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step("R3", 4'b1111, 4'b1111, 1'b0, 0);
      cmp("R3 rotation order", int'(grant_id), i);
    end

    // near-exhaustive sweep of valid and kind patterns with rotating returns
    for (int v = 0; v < 16; v++) begin
      for (int l = 0; l < 16; l++) begin
        do_reset();
        for (int c = 0; c < 8; c++) step("R4 sweep", 4'(v), 4'(l), 1'b1, c % NW);
      end
    end

    // random traffic
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      step("R3 random", 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), int'($urandom_range(0, NW - 1)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule